// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged Read Lookup Unit

This block is the read side of an 8 KB direct-mapped data cache with 32-byte lines. A request carries a virtual address. In the cycle the request is accepted, the low address bits select a set and the tag, valid and data arrays are read. In that same cycle the virtual page number goes out on a translation port. When the physical page number comes back, it is compared with the stored tag. A match on a valid line is a hit, and the requested 32-bit word is returned. Anything else is a miss. The line is then fetched from memory and written over the single line at that index.

The pages are 4 KB, but the cache spans 8 KB, so index bit 12 comes from the virtual address and lies above the page offset. Two virtual mappings of one physical page can therefore place the same physical line at two indices that differ only in that bit. On every miss the block probes the partner index, the one with bit 12 inverted. If that line is valid and holds the same physical page, the block invalidates it before it asks memory for the refill. At most one valid copy of any physical line ever exists.

The unit serves one request at a time. It holds `req_ready` low from acceptance until its response pulse.

Top module: `vipt_lookup`

## Requirements
- R1: Reset clears every valid bit. After reset `req_ready` is 1, `rsp_valid` and `mem_req_valid` are 0, and the first access to any address is a miss.
- R2: In the cycle a request is accepted (`req_valid` and `req_ready`), `xlat_req_valid` is 1 and `xlat_vpn` equals `req_vaddr[31:12]`. The array read uses `req_vaddr[12:5]` as index in that same cycle.
- R3: After acceptance the block waits for `xlat_rsp_valid` and raises no response before it arrives. A hit response appears one cycle after the cycle in which `xlat_rsp_valid` is sampled.
- R4: A hit needs the line's valid bit set and its stored tag equal to `xlat_ppn`. It gives `rsp_hit`=1 and issues no memory request. `rsp_data` is word `req_vaddr[4:2]`, where word w occupies bits [32w+31:32w] of the line.
- R5: On a miss the block raises `mem_req_valid` with `mem_req_addr` = {physical page number, `req_vaddr[11:5]`, 5'b0}. Request and address stay stable until `mem_rsp_valid`.
- R6: When `mem_rsp_valid` arrives, the block writes `mem_rsp_line` into the line and sets its tag and valid bit. It also returns a response with `rsp_hit`=0 and the requested word taken from that line. A repeat access then hits.
- R7: On a miss, if the line at the index with bit 12 inverted is valid and holds the same physical page, it is invalidated. `alias_evict` pulses for one cycle, before the memory request. Two valid copies of one physical line never coexist.
- R8: A valid line at the index that holds another page is a miss and is replaced. `alias_evict` stays low when the partner index does not hold the requested page.
- R9: Each accepted request yields exactly one single-cycle `rsp_valid` pulse.
- R10: `req_ready` stays 0 from acceptance until the response, so no second request is taken while one is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_vaddr | input | 32 | Virtual byte address of the read |
| req_ready | output | 1 | Block idle and able to take a request |
| xlat_req_valid | output | 1 | Translation request strobe |
| xlat_vpn | output | 20 | Virtual page number to translate |
| xlat_rsp_valid | input | 1 | Translation result present |
| xlat_ppn | input | 20 | Physical page number |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_hit | output | 1 | Response came from a hit |
| rsp_data | output | 32 | Requested word |
| alias_evict | output | 1 | Partner-index copy invalidated this cycle |
| mem_req_valid | output | 1 | Line fetch request |
| mem_req_addr | output | 32 | Physical line address of the fetch |
| mem_rsp_valid | input | 1 | Fetched line present |
| mem_rsp_line | input | 256 | Fetched line contents |

## Verification
Two things happen in the same cycle when a request is accepted: the virtual page number goes to the translation port, and the set is read from the arrays. On a hit the answer comes straight out of that read, with no second array access. The bench checks the translation port in the acceptance cycle. For hits it counts cycles: the response must follow the translation result by exactly one cycle, both with an immediate translation reply and with one delayed by three cycles. Two virtual pages that differ in bit 12 are mapped to one physical page and accessed in turn. Each switch must miss, raise exactly one eviction pulse and return the same physical word.

// File: rtl/vipt_pkg.sv
`timescale 1ns/1ps
package vipt_pkg;
    parameter int ADDR_W     = 32;
    parameter int PAGE_OFF_W = 12;
    parameter int LINE_OFF_W = 5;
    parameter int IDX_W      = 8;
    parameter int WORD_W     = 32;

    localparam int PN_W    = ADDR_W - PAGE_OFF_W;
    localparam int SETS    = 1 << IDX_W;
    localparam int LINE_W  = (1 << LINE_OFF_W) * 8;
    localparam int WORDS   = LINE_W / WORD_W;
    localparam int WSEL_W  = $clog2(WORDS);
    localparam int BYTE_W  = $clog2(WORD_W / 8);
    // index bits that lie above the page offset: exactly one in this geometry
    localparam int ALIAS_POS = IDX_W - 1;

    typedef logic [PN_W-1:0]   pn_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [WSEL_W-1:0] wsel_t;
    typedef logic [LINE_W-1:0] line_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        logic valid;
        pn_t  tag;
    } tag_ent_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOK,
        ST_PROBE,
        ST_FILL
    } lk_state_t;

    function automatic idx_t idx_of(addr_t a);
        return a[LINE_OFF_W+IDX_W-1:LINE_OFF_W];
    endfunction

    function automatic wsel_t wsel_of(addr_t a);
        return a[LINE_OFF_W-1:BYTE_W];
    endfunction

    function automatic idx_t partner_of(idx_t i);
        idx_t p;
        p = i;
        p[ALIAS_POS] = ~i[ALIAS_POS];
        return p;
    endfunction

    function automatic word_t pick_word(line_t l, wsel_t w);
        return l[w*WORD_W +: WORD_W];
    endfunction
endpackage

// File: rtl/vipt_tag_store.sv
`timescale 1ns/1ps
module vipt_tag_store
    import vipt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  idx_t     rd_idx,
    output tag_ent_t rd_ent,
    input  idx_t     probe_idx,
    output tag_ent_t probe_ent,
    input  logic     wr_en,
    input  idx_t     wr_idx,
    input  pn_t      wr_tag,
    input  logic     clr_en,
    input  idx_t     clr_idx
);
    logic [SETS-1:0] valid_q;
    pn_t             tag_q [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else begin
            if (clr_en) valid_q[clr_idx] <= 1'b0;
            if (wr_en)  valid_q[wr_idx]  <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) tag_q[wr_idx] <= wr_tag;
    end

    assign rd_ent    = '{valid: valid_q[rd_idx],    tag: tag_q[rd_idx]};
    assign probe_ent = '{valid: valid_q[probe_idx], tag: tag_q[probe_idx]};

    // R7: the two indices that differ only in the top index bit never both hold
    // a valid copy of the same physical page
    for (genvar i = 0; i < SETS / 2; i++) begin : g_pair
        always_comb begin
            if (!rst) begin
                p_one_copy_r7: assert (!(valid_q[i] && valid_q[i + SETS/2] &&
                                         (tag_q[i] == tag_q[i + SETS/2])))
                    else $error("two valid copies at index pair %0d", i);
            end
        end
    end
endmodule

// File: rtl/vipt_data_store.sv
`timescale 1ns/1ps
module vipt_data_store
    import vipt_pkg::*;
(
    input  logic  clk,
    input  logic  rd_en,
    input  idx_t  rd_idx,
    input  wsel_t rd_wsel,
    output word_t rd_word,
    input  logic  wr_en,
    input  idx_t  wr_idx,
    input  line_t wr_line
);
    line_t lines_q [SETS];

    always_ff @(posedge clk) begin
        if (wr_en) lines_q[wr_idx] <= wr_line;
    end

    always_ff @(posedge clk) begin
        if (rd_en) rd_word <= pick_word(lines_q[rd_idx], rd_wsel);
    end
endmodule

// File: rtl/vipt_ctrl.sv
`timescale 1ns/1ps
module vipt_ctrl
    import vipt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     req_valid,
    input  addr_t    req_vaddr,
    output logic     req_ready,
    output logic     xlat_req_valid,
    output pn_t      xlat_vpn,
    input  logic     xlat_rsp_valid,
    input  pn_t      xlat_ppn,
    output logic     rsp_valid,
    output logic     rsp_hit,
    output word_t    rsp_data,
    output logic     alias_evict,
    output logic     mem_req_valid,
    output addr_t    mem_req_addr,
    input  logic     mem_rsp_valid,
    input  line_t    mem_rsp_line,
    output idx_t     ts_rd_idx,
    input  tag_ent_t ts_rd_ent,
    output idx_t     ts_probe_idx,
    input  tag_ent_t ts_probe_ent,
    output logic     ts_wr_en,
    output idx_t     ts_wr_idx,
    output pn_t      ts_wr_tag,
    output logic     ts_clr_en,
    output idx_t     ts_clr_idx,
    output logic     ds_rd_en,
    output idx_t     ds_rd_idx,
    output wsel_t    ds_rd_wsel,
    input  word_t    ds_rd_word,
    output logic     ds_wr_en,
    output idx_t     ds_wr_idx,
    output line_t    ds_wr_line
);
    lk_state_t state_q, state_d;
    idx_t      idx_q;
    wsel_t     wsel_q;
    tag_ent_t  ent_q;
    pn_t       ppn_q;
    logic      accept, look_hit, look_done, fill_done;
    logic      unused_lowbits;

    assign unused_lowbits = ^req_vaddr[BYTE_W-1:0];

    assign req_ready      = (state_q == ST_IDLE);
    assign accept         = req_valid && req_ready;
    assign xlat_req_valid = accept;
    assign xlat_vpn       = req_vaddr[ADDR_W-1:PAGE_OFF_W];

    // set selection proceeds alongside translation
    assign ts_rd_idx  = idx_of(req_vaddr);
    assign ds_rd_en   = accept;
    assign ds_rd_idx  = idx_of(req_vaddr);
    assign ds_rd_wsel = wsel_of(req_vaddr);

    assign look_hit  = ent_q.valid && (ent_q.tag == xlat_ppn);
    assign look_done = (state_q == ST_LOOK) && xlat_rsp_valid;
    assign fill_done = (state_q == ST_FILL) && mem_rsp_valid;

    assign ts_probe_idx = partner_of(idx_q);
    assign ts_clr_idx   = ts_probe_idx;

    assign mem_req_valid = (state_q == ST_FILL);
    assign mem_req_addr  = {ppn_q, idx_q[IDX_W-2:0], {LINE_OFF_W{1'b0}}};

    assign ts_wr_en   = fill_done;
    assign ts_wr_idx  = idx_q;
    assign ts_wr_tag  = ppn_q;
    assign ds_wr_en   = fill_done;
    assign ds_wr_idx  = idx_q;
    assign ds_wr_line = mem_rsp_line;

    always_comb begin
        state_d     = state_q;
        ts_clr_en   = 1'b0;
        alias_evict = 1'b0;
        case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_LOOK;
            ST_LOOK:  if (xlat_rsp_valid) state_d = look_hit ? ST_IDLE : ST_PROBE;
            ST_PROBE: begin
                if (ts_probe_ent.valid && (ts_probe_ent.tag == ppn_q)) begin
                    ts_clr_en   = 1'b1;
                    alias_evict = 1'b1;
                end
                state_d = ST_FILL;
            end
            ST_FILL:  if (mem_rsp_valid) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            rsp_valid <= 1'b0;
        end else begin
            state_q   <= state_d;
            rsp_valid <= (look_done && look_hit) || fill_done;
        end
    end

    always_ff @(posedge clk) begin
        if (accept) begin
            idx_q  <= idx_of(req_vaddr);
            wsel_q <= wsel_of(req_vaddr);
            ent_q  <= ts_rd_ent;
        end
        if (look_done) begin
            ppn_q    <= xlat_ppn;
            rsp_hit  <= 1'b1;
            rsp_data <= ds_rd_word;
        end
        if (fill_done) begin
            rsp_hit  <= 1'b0;
            rsp_data <= pick_word(mem_rsp_line, wsel_q);
        end
    end

    // R3: without a translation result the lookup holds and answers nothing
    p_stall_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LOOK && !xlat_rsp_valid) |=> (state_q == ST_LOOK && !rsp_valid));

    // R5: a line fetch stays posted with a steady address until served
    p_req_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_rsp_valid) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R6: a miss response is always the cycle after the fetched line arrived
    p_miss_after_fill_r6: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> $past(mem_rsp_valid));

    // R7: the partner copy is dropped before the fetch is posted
    p_evict_then_fetch_r7: assert property (@(posedge clk) disable iff (rst)
        alias_evict |=> mem_req_valid);

    // R9: responses are single-cycle pulses
    p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);
endmodule

// File: rtl/vipt_lookup.sv
`timescale 1ns/1ps
module vipt_lookup
    import vipt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_vaddr,
    output logic              req_ready,
    output logic              xlat_req_valid,
    output logic [PN_W-1:0]   xlat_vpn,
    input  logic              xlat_rsp_valid,
    input  logic [PN_W-1:0]   xlat_ppn,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [WORD_W-1:0] rsp_data,
    output logic              alias_evict,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [LINE_W-1:0] mem_rsp_line
);
    idx_t     ts_rd_idx, ts_probe_idx, ts_wr_idx, ts_clr_idx;
    tag_ent_t ts_rd_ent, ts_probe_ent;
    logic     ts_wr_en, ts_clr_en;
    pn_t      ts_wr_tag;
    logic     ds_rd_en, ds_wr_en;
    idx_t     ds_rd_idx, ds_wr_idx;
    wsel_t    ds_rd_wsel;
    word_t    ds_rd_word;
    line_t    ds_wr_line;

    vipt_ctrl u_ctrl (
        .clk            (clk),
        .rst            (rst),
        .req_valid      (req_valid),
        .req_vaddr      (req_vaddr),
        .req_ready      (req_ready),
        .xlat_req_valid (xlat_req_valid),
        .xlat_vpn       (xlat_vpn),
        .xlat_rsp_valid (xlat_rsp_valid),
        .xlat_ppn       (xlat_ppn),
        .rsp_valid      (rsp_valid),
        .rsp_hit        (rsp_hit),
        .rsp_data       (rsp_data),
        .alias_evict    (alias_evict),
        .mem_req_valid  (mem_req_valid),
        .mem_req_addr   (mem_req_addr),
        .mem_rsp_valid  (mem_rsp_valid),
        .mem_rsp_line   (mem_rsp_line),
        .ts_rd_idx      (ts_rd_idx),
        .ts_rd_ent      (ts_rd_ent),
        .ts_probe_idx   (ts_probe_idx),
        .ts_probe_ent   (ts_probe_ent),
        .ts_wr_en       (ts_wr_en),
        .ts_wr_idx      (ts_wr_idx),
        .ts_wr_tag      (ts_wr_tag),
        .ts_clr_en      (ts_clr_en),
        .ts_clr_idx     (ts_clr_idx),
        .ds_rd_en       (ds_rd_en),
        .ds_rd_idx      (ds_rd_idx),
        .ds_rd_wsel     (ds_rd_wsel),
        .ds_rd_word     (ds_rd_word),
        .ds_wr_en       (ds_wr_en),
        .ds_wr_idx      (ds_wr_idx),
        .ds_wr_line     (ds_wr_line)
    );

    vipt_tag_store u_tags (
        .clk       (clk),
        .rst       (rst),
        .rd_idx    (ts_rd_idx),
        .rd_ent    (ts_rd_ent),
        .probe_idx (ts_probe_idx),
        .probe_ent (ts_probe_ent),
        .wr_en     (ts_wr_en),
        .wr_idx    (ts_wr_idx),
        .wr_tag    (ts_wr_tag),
        .clr_en    (ts_clr_en),
        .clr_idx   (ts_clr_idx)
    );

    vipt_data_store u_data (
        .clk     (clk),
        .rd_en   (ds_rd_en),
        .rd_idx  (ds_rd_idx),
        .rd_wsel (ds_rd_wsel),
        .rd_word (ds_rd_word),
        .wr_en   (ds_wr_en),
        .wr_idx  (ds_wr_idx),
        .wr_line (ds_wr_line)
    );
endmodule

// File: tb/vipt_lookup_tb.sv
`timescale 1ns/1ps
module vipt_lookup_tb;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic [31:0]  req_vaddr = '0;
    logic         req_ready;
    logic         xlat_req_valid;
    logic [19:0]  xlat_vpn;
    logic         xlat_rsp_valid = 1'b0;
    logic [19:0]  xlat_ppn = '0;
    logic         rsp_valid, rsp_hit;
    logic [31:0]  rsp_data;
    logic         alias_evict;
    logic         mem_req_valid;
    logic [31:0]  mem_req_addr;
    logic         mem_rsp_valid = 1'b0;
    logic [255:0] mem_rsp_line = '0;

    int errors = 0, checks = 0;
    int xlat_extra = 0, mem_lat = 2;
    int evict_cnt = 0, rsp_cnt = 0, fetch_cnt = 0;
    logic [31:0] last_fetch = '0;

    typedef struct { logic [31:0] data; bit hit; } exp_t;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    vipt_lookup u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_ready(req_ready), .xlat_req_valid(xlat_req_valid), .xlat_vpn(xlat_vpn),
        .xlat_rsp_valid(xlat_rsp_valid), .xlat_ppn(xlat_ppn), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_data(rsp_data), .alias_evict(alias_evict),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_line(mem_rsp_line)
    );

    function automatic logic [19:0] ppn_of(logic [19:0] vpn);
        if (vpn == 20'h00010 || vpn == 20'h00011) return 20'h00400;
        return vpn + 20'h00100;
    endfunction

    function automatic logic [31:0] mem_word(logic [31:0] pa);
        return {pa[31:2], 2'b00} ^ 32'h3C3C_0000;
    endfunction

    function automatic logic [255:0] mem_line(logic [31:0] la);
        logic [255:0] l;
        for (int w = 0; w < 8; w++) l[w*32 +: 32] = mem_word({la[31:5], w[2:0], 2'b00});
        return l;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // translation model: answers in the cycle after the request plus xlat_extra
    initial begin
        logic [19:0] pend;
        int cnt;
        cnt = 0;
        pend = '0;
        forever begin
            @(posedge clk);
            xlat_rsp_valid <= 1'b0;
            if (cnt > 0) begin
                cnt--;
                if (cnt == 0) begin
                    xlat_rsp_valid <= 1'b1;
                    xlat_ppn <= ppn_of(pend);
                end
            end else if (xlat_req_valid) begin
                pend = xlat_vpn;
                if (xlat_extra == 0) begin
                    xlat_rsp_valid <= 1'b1;
                    xlat_ppn <= ppn_of(pend);
                end else cnt = xlat_extra;
            end
        end
    end

    // memory model
    initial begin
        int cnt;
        bit busy;
        cnt = 0;
        busy = 0;
        forever begin
            @(posedge clk);
            mem_rsp_valid <= 1'b0;
            if (!mem_req_valid) busy = 0;
            if (cnt > 0) begin
                cnt--;
                if (cnt == 0) begin
                    mem_rsp_valid <= 1'b1;
                    mem_rsp_line <= mem_line(last_fetch);
                end
            end else if (mem_req_valid && !busy) begin
                busy = 1;
                fetch_cnt++;
                last_fetch = mem_req_addr;
                if (mem_lat == 0) begin
                    mem_rsp_valid <= 1'b1;
                    mem_rsp_line <= mem_line(last_fetch);
                end else cnt = mem_lat;
            end
        end
    end

    // scoreboard monitor
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (!rst && alias_evict) evict_cnt++;
            if (!rst && rsp_valid) begin
                rsp_cnt++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9 unexpected response", {31'd0, rsp_valid}, 32'd0);
                end else begin
                    e = exp_q.pop_front();
                    check(rsp_hit == e.hit, e.hit ? "R4 hit flag" : "R6 hit flag",
                          {31'd0, rsp_hit}, {31'd0, e.hit});
                    check(rsp_data == e.data, e.hit ? "R4 data" : "R6 data",
                          rsp_data, e.data);
                end
            end
        end
    end

    task automatic push_exp(input logic [31:0] va, input bit hit);
        exp_t e;
        e.data = mem_word({ppn_of(va[31:12]), va[11:0]});
        e.hit  = hit;
        exp_q.push_back(e);
    endtask

    // drives one request at the negedge where the block is idle; returns after it
    task automatic issue(input logic [31:0] va);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = va;
        #1;
        check(xlat_req_valid && xlat_vpn == va[31:12], "R2 translation port",
              {11'd0, xlat_req_valid, xlat_vpn}, {12'h001, va[31:12]});
    endtask

    task automatic access(input logic [31:0] va, input bit exp_hit, input int exp_ev);
        int ev0, f0, r0;
        ev0 = evict_cnt;
        f0 = fetch_cnt;
        r0 = rsp_cnt;
        push_exp(va, exp_hit);
        issue(va);
        @(negedge clk);
        req_valid = 1'b0;
        while (rsp_cnt == r0) @(negedge clk);
        check(evict_cnt - ev0 == exp_ev, exp_ev != 0 ? "R7 evict count" : "R8 evict count",
              evict_cnt - ev0, exp_ev);
        check(fetch_cnt - f0 == (exp_hit ? 0 : 1), exp_hit ? "R4 no fetch" : "R5 one fetch",
              fetch_cnt - f0, exp_hit ? 0 : 1);
        if (!exp_hit)
            check(last_fetch == {ppn_of(va[31:12]), va[11:5], 5'b0}, "R5 fetch address",
                  last_fetch, {ppn_of(va[31:12]), va[11:5], 5'b0});
    endtask

    // hit with exact cycle accounting from acceptance to response
    task automatic timed_hit(input logic [31:0] va, input int extra);
        xlat_extra = extra;
        push_exp(va, 1'b1);
        issue(va);
        for (int k = 1; k <= extra + 1; k++) begin
            @(negedge clk);
            if (k == 1) req_valid = 1'b0;
            check(!rsp_valid, "R3 no early response", {31'd0, rsp_valid}, 32'd0);
            check(!req_ready, "R10 busy", {31'd0, req_ready}, 32'd0);
        end
        @(negedge clk);
        check(rsp_valid, "R3 response latency", {31'd0, rsp_valid}, 32'd1);
        xlat_extra = 0;
    endtask

    localparam logic [31:0] VA_A = 32'h0001_0044;  // index 0x02, maps to page 0x400
    localparam logic [31:0] VA_B = 32'h0001_1044;  // index 0x82, same physical page
    localparam logic [31:0] VA_C = 32'h0003_0044;  // index 0x02, other page
    localparam logic [31:0] VA_D = 32'h0002_0FFC;  // last word of index 0x7F

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(req_ready && !rsp_valid && !mem_req_valid, "R1 reset outputs",
              {29'd0, req_ready, rsp_valid, mem_req_valid}, 32'h4);
        access(VA_A, 1'b0, 0);           // R1 cold miss
        timed_hit(VA_A, 0);              // R3 immediate translation, R4
        access(VA_A + 32'h8, 1'b1, 0);   // R4 other word of line
        access(VA_B, 1'b0, 1);           // R7 synonym at partner index
        access(VA_A, 1'b0, 1);           // R7 only one copy remained
        access(VA_B, 1'b0, 1);           // R7
        access(VA_C, 1'b0, 0);           // R8 conflict, partner holds other page
        access(VA_A, 1'b0, 1);           // R8 replaced, partner B evicted
        timed_hit(VA_A, 3);              // R3 delayed translation, R10
        mem_lat = 5;
        access(VA_D, 1'b0, 0);           // R6 last word, slow memory
        access(VA_D, 1'b1, 0);           // R6 refill left line valid
        mem_lat = 0;
        access(VA_B, 1'b0, 1);           // R7
        access(VA_A, 1'b0, 1);           // R7
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R9 outstanding responses", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule